// File: doc/BRIEF.md
# DMA Transfer Counter Unit

This block holds the byte count of a DMA transfer for a SCSI protocol controller. Software programs a 24-bit start count through three byte-wide registers. The block keeps that start count apart from a working counter. The working counter is reloaded from the start count only when a command carrying the DMA flag is issued. A start count of zero loads as 65536.

The working counter counts down as data moves, in either of two ways. The data path can request a multi-byte decrement. A pseudo-DMA port can also push single bytes, and each byte counts only while the DMA request line is high and the counter is nonzero. The counter stops at zero and never wraps. A terminal-count flag marks the cycle in which the counter falls from a nonzero value to zero, and any issued command clears that flag again.

The working count is read back through the same byte addresses. The high-count address is special: until software first writes it, a read there returns an 8-bit identifier that is set by a parameter. This lets a driver probe which controller variant is present. Bus phase tracking and data storage are handled by neighbouring logic.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset the working count is 0, `tc_flag` is 0, reads of offsets 0 and 1 return 0, and a read of offset 2 returns `CHIP_ID`.
- R2: A write with `reg_wr` high stores `reg_wdata` into a start-count byte: offset 0 holds bits 7:0, offset 1 holds bits 15:8 and offset 2 holds bits 23:16. Such a write leaves the working count read back at those offsets unchanged.
- R3: When `cmd_issue` and `cmd_dma` are both high, the working count is loaded from the start count at the next edge. When `cmd_issue` is high and `cmd_dma` is low, the working count is not changed.
- R4: If the start count is zero when a DMA command is issued, the working count loads 0x010000.
- R5: A read returns working-count bits 7:0 at offset 0, bits 15:8 at offset 1 and bits 23:16 at offset 2, subject to R6. A read at offset 3 returns 0.
- R6: A read of offset 2 returns `CHIP_ID` until offset 2 has been written once since reset. After that it returns count bits 23:16. A reset restores the identifier read.
- R7: With `dec_valid` high, the working count drops by `dec_amount` at the next edge. If `dec_amount` exceeds the count, the count stops at 0.
- R8: A `pdma_push` decrements the count by 1 only when `drq` is high and the count is nonzero. Otherwise the push has no effect on the count.
- R9: `tc_flag` sets only when the count goes from nonzero to zero. Decrementing a zero count does not set it, and the flag holds until it is cleared.
- R10: Any `cmd_issue` clears `tc_flag`. If a nonzero-to-zero transition happens in the same cycle, the flag is set instead.
- R11: A DMA command wins over a decrement in the same cycle: the count loads the start count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cmd_issue | input | 1 | A command is issued this cycle |
| cmd_dma | input | 1 | The issued command carries the DMA flag |
| dec_valid | input | 1 | Apply a decrement this cycle |
| dec_amount | input | DEC_W | Number of bytes moved |
| pdma_push | input | 1 | One byte pushed through the pseudo-DMA port |
| drq | input | 1 | DMA request line level |
| tc_flag | output | 1 | Terminal-count status |

## Verification
Two pairs of functions can coincide in one cycle, and both are provoked deliberately.

- A DMA command issued together with a large decrement: the bench judges the count read afterwards against the start count, not against a decremented value.
- A command without the DMA flag issued in the cycle that a decrement drives the count from 1 to 0: here the flag clear and the terminal-count set collide, and the bench expects `tc_flag` high.

The pseudo-DMA byte and the data-path decrement are also exercised on a zero count, to confirm that the flag does not set.

// File: rtl/xcu_pkg.sv
package xcu_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic int unsigned byte_count(input int unsigned bits);
    return (bits + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/xcu_rst_sync.sv
module xcu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/xcu_start_bank.sv
module xcu_start_bank
  import xcu_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  output logic [CNT_W-1:0]  start_cnt,
  output logic              hi_written
);
  localparam int unsigned NB = byte_count(CNT_W);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(NB - 1);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic  wr_en;
    byte_t byte_q;
    byte_t byte_d;

    always_comb begin
      wr_en  = wr && (addr == ADDR_W'(i));
      byte_d = wr_en ? wdata : byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (wr_en) begin
        byte_q <= byte_d;
      end
    end

    assign start_cnt[i*BYTE_W +: BYTE_W] = byte_q;
  end

  logic hi_q;
  logic hi_d;

  always_comb begin
    hi_d = hi_q | (wr && (addr == HI_ADDR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
    end
  end

  assign hi_written = hi_q;
endmodule

// File: rtl/xcu_work_counter.sv
module xcu_work_counter #(
  parameter int unsigned             CNT_W     = 24,
  parameter int unsigned             DEC_W     = 16,
  parameter logic [CNT_W-1:0]        ZERO_LOAD = CNT_W'(32'h0001_0000)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_issue,
  input  logic             cmd_dma,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             dec_valid,
  input  logic [DEC_W-1:0] dec_amount,
  input  logic             pdma_push,
  input  logic             drq,
  output logic [CNT_W-1:0] cnt,
  output logic             tc
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             tc_q;
  logic             tc_d;
  logic             reload;
  logic             pdma_fire;
  logic [SUM_W-1:0] dec_total;
  logic             cnt_nz;

  always_comb begin
    cnt_nz    = (cnt_q != '0);
    reload    = cmd_issue && cmd_dma;
    pdma_fire = pdma_push && drq && cnt_nz;
    dec_total = (dec_valid ? SUM_W'(dec_amount) : '0) + SUM_W'(pdma_fire);

    if (reload) begin
      cnt_d = (start_cnt == '0) ? ZERO_LOAD : start_cnt;
    end else if (dec_total >= {1'b0, cnt_q}) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q - dec_total[CNT_W-1:0];
    end

    cnt_en = reload || (dec_total != '0);
    tc_d   = (tc_q && !cmd_issue) || (cnt_nz && (cnt_d == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= 1'b0;
    end else begin
      tc_q <= tc_d;
    end
  end

  assign cnt = cnt_q;
  assign tc  = tc_q;
endmodule

// File: rtl/xcu_read_mux.sv
module xcu_read_mux
  import xcu_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned ADDR_W  = 2,
  parameter byte_t       CHIP_ID = 8'hA2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hi_written,
  output byte_t             rdata
);
  localparam int unsigned NB = byte_count(CNT_W);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(NB - 1);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr == ADDR_W'(i)) begin
        rdata = cnt[i*BYTE_W +: BYTE_W];
      end
    end
    if ((addr == HI_ADDR) && !hi_written) begin
      rdata = CHIP_ID;
    end
  end
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
  import xcu_pkg::*;
#(
  parameter int unsigned      CNT_W     = 24,
  parameter int unsigned      ADDR_W    = 2,
  parameter int unsigned      DEC_W     = 16,
  parameter logic [7:0]       CHIP_ID   = 8'hA2,
  parameter logic [CNT_W-1:0] ZERO_LOAD = CNT_W'(32'h0001_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cmd_issue,
  input  logic              cmd_dma,
  input  logic              dec_valid,
  input  logic [DEC_W-1:0]  dec_amount,
  input  logic              pdma_push,
  input  logic              drq,
  output logic              tc_flag
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] start_cnt;
  logic [CNT_W-1:0] work_cnt;
  logic             hi_written;

  xcu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xcu_start_bank #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_start (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .start_cnt  (start_cnt),
    .hi_written (hi_written)
  );

  xcu_work_counter #(
    .CNT_W     (CNT_W),
    .DEC_W     (DEC_W),
    .ZERO_LOAD (ZERO_LOAD)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_issue  (cmd_issue),
    .cmd_dma    (cmd_dma),
    .start_cnt  (start_cnt),
    .dec_valid  (dec_valid),
    .dec_amount (dec_amount),
    .pdma_push  (pdma_push),
    .drq        (drq),
    .cnt        (work_cnt),
    .tc         (tc_flag)
  );

  xcu_read_mux #(
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .CHIP_ID (CHIP_ID)
  ) u_rd (
    .addr       (reg_addr),
    .cnt        (work_cnt),
    .hi_written (hi_written),
    .rdata      (reg_rdata)
  );
endmodule

// File: rtl/xcu_checker.sv
module xcu_checker #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned ADDR_W  = 2,
  parameter logic [7:0]  CHIP_ID = 8'hA2
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              cmd_issue,
  input logic              cmd_dma,
  input logic [CNT_W-1:0]  work_cnt,
  input logic              tc_flag,
  input logic              hi_written,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_rdata
);
  localparam int unsigned NB = (CNT_W + 7) / 8;
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(NB - 1);

  AST_TC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(tc_flag) |-> (work_cnt == '0)); // R9
  AST_TC_FROM_NONZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(tc_flag) |-> ($past(work_cnt) != '0)); // R9
  AST_RELOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_issue && cmd_dma) |=> (work_cnt != '0)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cmd_issue && cmd_dma) |=> (work_cnt <= $past(work_cnt))); // R7
  AST_ID_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hi_written |=> hi_written); // R6
  AST_ID_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!hi_written && (reg_addr == HI_ADDR)) |-> (reg_rdata == CHIP_ID)); // R6
endmodule

bind xfer_count_unit xcu_checker #(
  .CNT_W   (CNT_W),
  .ADDR_W  (ADDR_W),
  .CHIP_ID (CHIP_ID)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cmd_issue  (cmd_issue),
  .cmd_dma    (cmd_dma),
  .work_cnt   (work_cnt),
  .tc_flag    (tc_flag),
  .hi_written (hi_written),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata)
);

// File: tb/xfer_count_unit_test.sv
module xfer_count_unit_test;
  localparam int PERIOD = 10;
  localparam logic [7:0] ID = 8'hA2;

  localparam logic [2:0] OP_WR = 3'd0, OP_RLD = 3'd1, OP_CMD = 3'd2, OP_DEC = 3'd3, OP_PDMA = 3'd4;
  localparam int NV = 22;
  // {op[2:0], arg[23:0], expected count[23:0], expected tc}
  localparam logic [51:0] VEC [NV] = '{
    {OP_WR,   24'h02_0000, 24'h000000, 1'b0},
    {OP_WR,   24'h01_0001, 24'h000000, 1'b0},
    {OP_WR,   24'h00_0005, 24'h000000, 1'b0},
    {OP_RLD,  24'h000000,  24'h000105, 1'b0},
    {OP_DEC,  24'h000005,  24'h000100, 1'b0},
    {OP_PDMA, 24'h000001,  24'h0000FF, 1'b0},
    {OP_PDMA, 24'h000000,  24'h0000FF, 1'b0},
    {OP_DEC,  24'h000200,  24'h000000, 1'b1},
    {OP_DEC,  24'h000003,  24'h000000, 1'b1},
    {OP_CMD,  24'h000000,  24'h000000, 1'b0},
    {OP_DEC,  24'h000001,  24'h000000, 1'b0},
    {OP_PDMA, 24'h000001,  24'h000000, 1'b0},
    {OP_WR,   24'h01_0000, 24'h000000, 1'b0},
    {OP_WR,   24'h00_0000, 24'h000000, 1'b0},
    {OP_RLD,  24'h000000,  24'h010000, 1'b0},
    {OP_DEC,  24'h00FFFF,  24'h000001, 1'b0},
    {OP_PDMA, 24'h000001,  24'h000000, 1'b1},
    {OP_WR,   24'h02_0003, 24'h000000, 1'b1},
    {OP_WR,   24'h01_0000, 24'h000000, 1'b1},
    {OP_WR,   24'h00_0002, 24'h000000, 1'b1},
    {OP_RLD,  24'h000000,  24'h030002, 1'b0},
    {OP_DEC,  24'h000003,  24'h02FFFF, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        cmd_issue = 1'b0;
  logic        cmd_dma = 1'b0;
  logic        dec_valid = 1'b0;
  logic [15:0] dec_amount = 16'd0;
  logic        pdma_push = 1'b0;
  logic        drq = 1'b0;
  logic        tc_flag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  xfer_count_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_issue(cmd_issue),
    .cmd_dma(cmd_dma), .dec_valid(dec_valid), .dec_amount(dec_amount),
    .pdma_push(pdma_push), .drq(drq), .tc_flag(tc_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus: set at a falling edge, cleared at the next one.
  task automatic pulse(input logic wr, input logic [1:0] a, input logic [7:0] d,
                       input logic ci, input logic cd, input logic dv,
                       input logic [15:0] amt, input logic pp, input logic dq);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    cmd_issue = ci; cmd_dma = cd; dec_valid = dv; dec_amount = amt;
    pdma_push = pp; drq = dq;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0; cmd_issue = 0; cmd_dma = 0;
    dec_valid = 0; dec_amount = 0; pdma_push = 0; drq = 0;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [23:0] arg);
    case (op)
      OP_WR:   pulse(1, arg[17:16], arg[7:0], 0, 0, 0, 16'd0, 0, 0);
      OP_RLD:  pulse(0, 2'd0, 8'd0, 1, 1, 0, 16'd0, 0, 0);
      OP_CMD:  pulse(0, 2'd0, 8'd0, 1, 0, 0, 16'd0, 0, 0);
      OP_DEC:  pulse(0, 2'd0, 8'd0, 0, 0, 1, arg[15:0], 0, 0);
      default: pulse(0, 2'd0, 8'd0, 0, 0, 0, 16'd0, 1, arg[0]);
    endcase
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic read_cnt(output logic [23:0] v);
    logic [7:0] b;
    rd(2'd0, b); v[7:0] = b;
    rd(2'd1, b); v[15:8] = b;
    rd(2'd2, b); v[23:16] = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [23:0] c;

    do_reset();
    // R1 reset state
    rd(2'd0, b); chk("R1 offset0 after reset", 32'(b), 32'h0);
    rd(2'd1, b); chk("R1 offset1 after reset", 32'(b), 32'h0);
    rd(2'd2, b); chk("R1 R6 offset2 returns id", 32'(b), 32'(ID));
    chk("R1 tc after reset", 32'(tc_flag), 32'h0);

    // Vector table: R2 R3 R4 R5 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][51:49], VEC[i][48:25]);
      read_cnt(c);
      chk($sformatf("R5 R7 R8 count vec %0d", i), 32'(c), 32'(VEC[i][24:1]));
      chk($sformatf("R9 R10 tc vec %0d", i), 32'(tc_flag), 32'(VEC[i][0]));
    end

    // R3: command without DMA flag leaves count as is (start is 0x030002)
    do_op(OP_CMD, 24'h0);
    read_cnt(c); chk("R3 no reload without dma flag", 32'(c), 32'h02FFFF);

    // R11: DMA command and decrement in the same cycle
    pulse(0, 2'd0, 8'd0, 1, 1, 1, 16'hFFFF, 1, 1);
    read_cnt(c); chk("R11 reload beats decrement", 32'(c), 32'h030002);

    // R10: clear and zero transition collide; set wins
    do_op(OP_WR, 24'h02_0000);
    do_op(OP_WR, 24'h00_0001);
    do_op(OP_RLD, 24'h0);
    read_cnt(c); chk("R3 reload to one", 32'(c), 32'h000001);
    pulse(0, 2'd0, 8'd0, 1, 0, 1, 16'd1, 0, 0);
    chk("R10 tc set wins over clear", 32'(tc_flag), 32'h1);
    read_cnt(c); chk("R7 count zero after collision", 32'(c), 32'h0);

    // R2: start write does not touch working count
    do_op(OP_WR, 24'h00_0077);
    read_cnt(c); chk("R2 start write leaves count", 32'(c), 32'h0);

    // R5: offset 3 reads zero
    rd(2'd3, b); chk("R5 offset3 reads zero", 32'(b), 32'h0);

    // R6: reset restores identifier, first write removes it
    do_reset();
    rd(2'd2, b); chk("R6 id after second reset", 32'(b), 32'(ID));
    do_op(OP_WR, 24'h02_0012);
    rd(2'd2, b); chk("R6 count byte after write", 32'(b), 32'h0);
    do_op(OP_RLD, 24'h0);
    read_cnt(c); chk("R6 R3 high byte readback", 32'(c), 32'h120000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule